// File: doc/BRIEF.md
# Per-Cluster CPU Clock Ratio Controller

This block sets the ratio between a PLL clock and the CPU clock of each of up to two processor clusters. Each cluster has an integer divider that produces a one-cycle clock-enable pulse. A pulse comes every N PLL cycles, so the cluster clock runs at the PLL frequency divided by N. Software does not change the running ratio directly. A value written into a cluster's control register only goes into a staging copy. The block uses it after a handshake: software sets the force bit, then raises a reload request. The block moves the staged ratio into the running divider at the next output-clock boundary, waits a fixed settle time and then sets that cluster's stable flag.

Each cluster runs a small state machine with three states. `ST_IDLE` holds the current ratio with the stable flag set. An accepted reload request takes it to `ST_ALIGN` and clears the flag. In `ST_ALIGN` it waits for the next output pulse. At that pulse the new ratio is applied and the machine moves to `ST_SETTLE`. `ST_SETTLE` counts `SETTLE_CYC` cycles, returns to `ST_IDLE` and sets the flag again. A request that is raised while the machine is not in `ST_IDLE` is not acted on.

Top module: `cpu_ratio_ctrl`

## Requirements
- R1: After reset, every cluster's stable flag is 1. Every cluster's running divider is 1, so its clock enable is high on every cycle. Every staging divider reads back as 1 with its force bit at 0.
- R2: Register map (byte addresses, cluster c, stride 0x14). The control register is at 0x000 + c*0x14, with the staged divider in bits [5:0] and force in bit 24. The request register is at 0x008 + c*0x14, with the reload request in bit 16. The status register is at 0x100, with cluster c's stable flag in bit c*STAT_STEP (STAT_STEP = 1 by default). All of these read back what was written or the current flag, and unused bits read 0.
- R3: Writing the control register alone does not change the spacing of the clock-enable pulses.
- R4: A request write that takes bit 16 from 0 to 1 while force is 1 and the cluster is idle is accepted. The stable flag is 0 in the next cycle. The staged ratio becomes active at the next clock-enable pulse.
- R5: The effective divider is 1 for a staged value of 0, 32 for a staged value above 32, and the staged value otherwise. After a reload completes, the enable pulses are spaced exactly that many cycles apart.
- R6: The stable flag returns to 1 a fixed `SETTLE_CYC` cycles after the new ratio becomes active. It stays at 1 until the next accepted request. The flag only falls in the cycle after a write to that cluster's request register.
- R7: A rising request while force is 0 is ignored. The stable flag stays 1 and the pulse spacing is unchanged.
- R8: Clearing bit 16 does not change the running ratio. Writing 1 to bit 16 while it is already 1 is not a new request. Bit 16 must go back to 0 before the next request is accepted.
- R9: The clusters are independent. A reload on one cluster leaves the other cluster's pulse spacing and stable flag unchanged.
- R10: The gap between consecutive clock-enable pulses of a cluster never exceeds 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Byte address for write and read |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr` (combinational) |
| clk_en | output | NUM_CL (2) | Per-cluster divided clock-enable pulse |
| ratio_stable | output | NUM_CL (2) | Per-cluster ratio stable flag |

## Verification
Cluster 0 is reprogrammed through every staged value from 0 to 40. This covers the zero case, the whole legal range and the clamp above 32. After each reload the pulse spacing is measured. Before each reload it is measured again, which shows the staging copy apart from the running divider. The other patterns are a request with force clear, a repeated request without clearing, and a clear-then-set request. These show the force gating and the rising-edge acceptance apart from level acceptance. Cluster 1 is measured while cluster 0 changes, which shows that the per-cluster address stride and the status bit positions are separate.

// File: rtl/cpu_ratio_pkg.sv
package cpu_ratio_pkg;

    // Register layout; the reload sequence depends on these positions.
    localparam int CTRL_OFS  = 'h000;
    localparam int REQ_OFS   = 'h008;
    localparam int CL_STRIDE = 'h14;
    localparam int STAT_OFS  = 'h100;
    localparam int FORCE_BIT = 24;
    localparam int REQ_BIT   = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_SETTLE = 2'd2
    } ratio_state_e;

endpackage

// File: rtl/cpu_ratio_divcnt.sv
module cpu_ratio_divcnt #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [DIV_W-1:0] new_div,
    output logic             tick
);
    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= DIV_W'(1);
            cnt_q <= '0;
        end else if (apply) begin
            act_q <= new_div;
            cnt_q <= new_div - DIV_W'(1);
        end else if (tick) begin
            cnt_q <= act_q - DIV_W'(1);
        end else begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end
endmodule

// File: rtl/cpu_ratio_fsm.sv
module cpu_ratio_fsm
    import cpu_ratio_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_rise,
    input  logic force_en,
    input  logic boundary,
    output logic apply,
    output logic stable
);
    ratio_state_e state_q, state_d;
    logic [CNT_W-1:0] settle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_rise && force_en) state_d = ST_ALIGN;
            ST_ALIGN:  if (boundary) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_q == CNT_W'(SETTLE_CYC - 1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign apply = (state_q == ST_ALIGN) && boundary;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
            stable   <= 1'b1;
        end else begin
            settle_q <= (state_q == ST_SETTLE) ? settle_q + CNT_W'(1) : '0;
            if (state_q == ST_IDLE && state_d == ST_ALIGN)
                stable <= 1'b0;
            else if (state_q == ST_SETTLE && state_d == ST_IDLE)
                stable <= 1'b1;
        end
    end
endmodule

// File: rtl/cpu_ratio_ctrl.sv
module cpu_ratio_ctrl
    import cpu_ratio_pkg::*;
#(
    parameter int NUM_CL     = 2,
    parameter int DIV_W      = 6,
    parameter int MAX_DIV    = 32,
    parameter int SETTLE_CYC = 4,
    parameter int STAT_STEP  = 1,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CL-1:0] clk_en,
    output logic [NUM_CL-1:0] ratio_stable
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic [NUM_CL-1:0][DIV_W-1:0] shadow_q;
    logic [NUM_CL-1:0]            force_q;
    logic [NUM_CL-1:0]            req_q;

    for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS + c * CL_STRIDE);
        localparam logic [ADDR_W-1:0] REQ_A  = ADDR_W'(REQ_OFS + c * CL_STRIDE);

        logic [DIV_W-1:0] shadow_r;
        logic             force_r;
        logic             req_r;
        logic [DIV_W-1:0] eff_div;
        logic             ctrl_hit, req_hit, req_rise, apply;

        assign ctrl_hit = wr_en && (addr == CTRL_A);
        assign req_hit  = wr_en && (addr == REQ_A);
        assign req_rise = req_hit && wdata[REQ_BIT] && !req_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_r <= DIV_W'(1);
                force_r  <= 1'b0;
                req_r    <= 1'b0;
            end else begin
                if (ctrl_hit) begin
                    shadow_r <= wdata[DIV_W-1:0];
                    force_r  <= wdata[FORCE_BIT];
                end
                if (req_hit) req_r <= wdata[REQ_BIT];
            end
        end

        always_comb begin
            if (shadow_r == '0)                       eff_div = DIV_W'(1);
            else if (int'(shadow_r) > MAX_DIV)        eff_div = DIV_W'(MAX_DIV);
            else                                      eff_div = shadow_r;
        end

        cpu_ratio_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_rise (req_rise),
            .force_en (force_r),
            .boundary (clk_en[c]),
            .apply    (apply),
            .stable   (ratio_stable[c])
        );

        cpu_ratio_divcnt #(.DIV_W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .apply   (apply),
            .new_div (eff_div),
            .tick    (clk_en[c])
        );

        assign shadow_q[c] = shadow_r;
        assign force_q[c]  = force_r;
        assign req_q[c]    = req_r;
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CL; c++) begin
            if (addr == ADDR_W'(CTRL_OFS + c * CL_STRIDE)) begin
                rdata[DIV_W-1:0] = shadow_q[c];
                rdata[FORCE_BIT] = force_q[c];
            end
            if (addr == ADDR_W'(REQ_OFS + c * CL_STRIDE))
                rdata[REQ_BIT] = req_q[c];
            if (addr == STAT_A)
                rdata[c * STAT_STEP] = ratio_stable[c];
        end
    end
endmodule

// File: rtl/cpu_ratio_ctrl_chk.sv
module cpu_ratio_ctrl_chk
    import cpu_ratio_pkg::*;
#(
    parameter int NUM_CL  = 2,
    parameter int MAX_DIV = 32,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NUM_CL-1:0] clk_en,
    input logic [NUM_CL-1:0] ratio_stable,
    input logic [NUM_CL-1:0] force_q,
    input logic [NUM_CL-1:0] req_q
);
    localparam int GAP_W = $clog2(MAX_DIV + 2) + 1;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ratio_stable == '1 && clk_en == '1));

    for (genvar c = 0; c < NUM_CL; c++) begin : g_c
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS + c * CL_STRIDE);
        localparam logic [ADDR_W-1:0] REQ_A  = ADDR_W'(REQ_OFS + c * CL_STRIDE);

        logic [GAP_W-1:0] gap_q;
        always_ff @(posedge clk) begin
            if (!rst_n)          gap_q <= '0;
            else if (clk_en[c])  gap_q <= '0;
            else if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
        end

        // R10
        max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(gap_q) < MAX_DIV);

        // R6
        fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ratio_stable[c]) |-> $past(wr_en && addr == REQ_A && wdata[REQ_BIT]));

        // R3
        ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CTRL_A && ratio_stable[c]) |=> ratio_stable[c]);

        // R4
        accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == REQ_A && wdata[REQ_BIT] && !req_q[c] && force_q[c]
             && ratio_stable[c]) |=> !ratio_stable[c]);

        // R7
        no_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == REQ_A && !force_q[c] && ratio_stable[c]) |=> ratio_stable[c]);
    end
endmodule

bind cpu_ratio_ctrl cpu_ratio_ctrl_chk #(
    .NUM_CL (NUM_CL),
    .MAX_DIV(MAX_DIV),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .clk_en       (clk_en),
    .ratio_stable (ratio_stable),
    .force_q      (force_q),
    .req_q        (req_q)
);

// File: tb/cpu_ratio_ctrl_tb.sv
module cpu_ratio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] CTRL0 = 12'h000, REQ0 = 12'h008;
    localparam logic [11:0] CTRL1 = 12'h014, REQ1 = 12'h01C, STAT = 12'h100;
    localparam logic [31:0] FORCE = 32'h0100_0000, RQ = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  clk_en, ratio_stable;

    int vecs = 0;
    int errs = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpu_ratio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_en(clk_en), .ratio_stable(ratio_stable)
    );

    function automatic int eff(input int d);
        if (d == 0) return 1;
        if (d > 32) return 32;
        return d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic period(input int c, output int g);
        int w = 0;
        while (!clk_en[c] && w < 100) begin @(negedge clk); w++; end
        g = 0;
        do begin @(negedge clk); g++; end while (!clk_en[c] && g < 100);
    endtask

    task automatic wait_stable(input int c, output int ok);
        int w = 0;
        while (!ratio_stable[c] && w < 200) begin @(negedge clk); w++; end
        ok = ratio_stable[c];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int g, ok, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 stable", int'(ratio_stable), 3);
        period(0, g); check("R1 period c0", g, 1);
        period(1, g); check("R1 period c1", g, 1);
        rd(CTRL0, v); check("R1 ctrl0 readback", int'(v), 1);

        // R5 sweep of every staged value, cluster 0
        prev = 1;
        for (int d = 0; d <= 40; d++) begin
            wr(CTRL0, FORCE | 32'(d));
            period(0, g); check("R3 staged only", g, prev);
            rd(CTRL0, v); check("R2 ctrl0 readback", int'(v), int'(FORCE | 32'(d & 63)));
            wr(REQ0, RQ);
            check("R4 stable cleared", int'(ratio_stable[0]), 0);
            wait_stable(0, ok); check("R6 stable returns", ok, 1);
            rd(STAT, v); check("R2 status bit0", int'(v[0]), 1);
            period(0, g); check("R5 new period", g, eff(d));
            wr(REQ0, 32'h0);
            check("R8 clear keeps stable", int'(ratio_stable[0]), 1);
            period(0, g); check("R8 clear keeps period", g, eff(d));
            if (d % 8 == 0) begin
                period(1, g); check("R9 c1 unaffected", g, 1);
                check("R9 c1 stable", int'(ratio_stable[1]), 1);
            end
            prev = eff(d);
        end

        // R7 request without force
        wr(CTRL1, 32'd5);
        wr(REQ1, RQ);
        check("R7 stable kept", int'(ratio_stable[1]), 1);
        repeat (40) @(negedge clk);
        check("R7 stable later", int'(ratio_stable[1]), 1);
        period(1, g); check("R7 period kept", g, 1);
        wr(REQ1, 32'h0);

        // R8 request held high is not a new request
        wr(CTRL1, FORCE | 32'd7);
        wr(REQ1, RQ);
        wait_stable(1, ok); check("R6 c1 stable", ok, 1);
        period(1, g); check("R5 c1 period 7", g, 7);
        rd(REQ1, v); check("R2 req1 readback", int'(v), int'(RQ));
        rd(STAT, v); check("R2 status bit1", int'(v[1]), 1);
        wr(CTRL1, FORCE | 32'd3);
        wr(REQ1, RQ);
        check("R8 repeat ignored", int'(ratio_stable[1]), 1);
        period(1, g); check("R8 repeat period", g, 7);
        wr(REQ1, 32'h0);
        wr(REQ1, RQ);
        check("R4 c1 cleared", int'(ratio_stable[1]), 0);
        wait_stable(1, ok); check("R6 c1 restable", ok, 1);
        period(1, g); check("R5 c1 period 3", g, 3);

        // R9 cluster 0 untouched by cluster 1 activity
        period(0, g); check("R9 c0 period", g, 32);
        check("R9 c0 stable", int'(ratio_stable[0]), 1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule